// File: doc/BRIEF.md
# Expansion Bus Chip-Select Translator

This block sits between an on-chip bus and an external expansion bus. It takes the offset of an access inside a 256 MB expansion window and produces two things: the address that is driven on the external pins, and a chip select that picks one of eight external devices. The chip selects are active low, and exactly one of them is asserted for each valid access.

The block has two map layouts. Each chip select has a large-device flag that comes from its timing configuration. While every flag is clear, each device gets a 16 MB region. The offset bits above that region pick the device, and the highest offset bit is ignored, so the lower 128 MB of the window repeats in the upper 128 MB. As soon as any flag is set, the whole window is laid out again with a 32 MB region per device. The mode is worked out again from the live flags on every access.

Results are registered, so the external address and the chip selects appear one clock after the access is presented.

Top module: `xbus_cs_xlate`

## Requirements
- R1: While reset is asserted, and on the first edge after it, every bit of `cs_n` is high (8'hFF) and `ext_addr` is zero.
- R2: The outputs change one clock edge after the inputs: the values sampled at edge k appear on `ext_addr`/`cs_n` after edge k and stay until edge k+1.
- R3: When `acc_valid` is low, every bit of `cs_n` is high and `ext_addr` is zero on the next cycle, whatever the offset and flags are.
- R4: In 16 MB mode (`big_dev` == 8'h00), `ext_addr[23:0]` equals `win_offset[23:0]` and `ext_addr[24]` is 0.
- R5: In 16 MB mode, `win_offset[26:24]` gives the index i of the selected device, and `cs_n[i]` is the bit driven low.
- R6: In 16 MB mode, `win_offset[27]` has no effect: two offsets that differ only in bit 27 give the same `ext_addr` and `cs_n`.
- R7: In 32 MB mode (any bit of `big_dev` set), `ext_addr[24:0]` equals `win_offset[24:0]`.
- R8: In 32 MB mode, `win_offset[27:25]` gives the index i of the selected device, and `cs_n[i]` is the bit driven low.
- R9: The mode comes from the `big_dev` value present with each access. Changing it between two back-to-back accesses changes the mapping of the second access with no extra delay.
- R10: For every valid access, exactly one bit of `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| win_offset | input | 28 | Offset of the access inside the expansion window |
| big_dev | input | 8 | Large-device flag of each chip select's timing configuration |
| ext_addr | output | 25 | Registered external bus address |
| cs_n | output | 8 | Registered chip selects, active low |

## Verification
The bench builds the block with its default parameters: eight chip selects and a 24-bit base region. With these values the widths are the real ones, a 28-bit offset and a 25-bit external address, so every region edge in both layouts falls on an exact address. The bench checks the first and last byte of each region in both modes, the bit-27 aliases in 16 MB mode, each single large-device flag on its own, and mode flips between back-to-back accesses. A pseudo-random run then mixes idle cycles with accesses in both modes.

// File: rtl/xbus_cs_pkg.sv
package xbus_cs_pkg;

    typedef enum logic {
        MAP_SMALL = 1'b0,
        MAP_LARGE = 1'b1
    } map_mode_e;

    localparam int unsigned XB_NUM_CS_DEF = 8;
    localparam int unsigned XB_SEG_W_DEF  = 24;

endpackage

// File: rtl/xbus_mode_detect.sv
module xbus_mode_detect
    import xbus_cs_pkg::*;
#(
    parameter int unsigned NUM_CS = XB_NUM_CS_DEF
) (
    input  logic [NUM_CS-1:0] big_dev,
    output map_mode_e         mode
);

    logic any_large;

    always_comb begin
        any_large = 1'b0;
        for (int i = 0; i < int'(NUM_CS); i++) begin
            any_large = any_large | big_dev[i];
        end
        mode = any_large ? MAP_LARGE : MAP_SMALL;
    end

endmodule

// File: rtl/xbus_addr_map.sv
module xbus_addr_map
    import xbus_cs_pkg::*;
#(
    parameter int unsigned NUM_CS = XB_NUM_CS_DEF,
    parameter int unsigned SEG_W  = XB_SEG_W_DEF,
    localparam int unsigned CS_W  = $clog2(NUM_CS),
    localparam int unsigned EXT_W = SEG_W + 1,
    localparam int unsigned OFS_W = SEG_W + 1 + CS_W
) (
    input  map_mode_e        mode,
    input  logic [OFS_W-1:0] offset,
    output logic [EXT_W-1:0] ext,
    output logic [CS_W-1:0]  idx
);

    // Small map: region of 2**SEG_W bytes, index just above it, top bit aliased.
    // Large map: region of 2**(SEG_W+1) bytes, index in the top bits.
    always_comb begin
        if (mode == MAP_LARGE) begin
            ext = offset[EXT_W-1:0];
            idx = offset[OFS_W-1:EXT_W];
        end else begin
            ext = {1'b0, offset[SEG_W-1:0]};
            idx = offset[SEG_W+CS_W-1:SEG_W];
        end
    end

endmodule

// File: rtl/xbus_cs_decode.sv
module xbus_cs_decode
    import xbus_cs_pkg::*;
#(
    parameter int unsigned NUM_CS = XB_NUM_CS_DEF,
    localparam int unsigned CS_W  = $clog2(NUM_CS)
) (
    input  logic              valid,
    input  logic [CS_W-1:0]   idx,
    output logic [NUM_CS-1:0] sel_n
);

    for (genvar g = 0; g < int'(NUM_CS); g++) begin : g_sel
        assign sel_n[g] = ~(valid && (idx == CS_W'(g)));
    end

endmodule

// File: rtl/xbus_cs_xlate.sv
module xbus_cs_xlate
    import xbus_cs_pkg::*;
#(
    parameter int unsigned NUM_CS = XB_NUM_CS_DEF,
    parameter int unsigned SEG_W  = XB_SEG_W_DEF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acc_valid,
    input  logic [SEG_W+$clog2(NUM_CS):0] win_offset,
    input  logic [NUM_CS-1:0]             big_dev,
    output logic [SEG_W:0]                ext_addr,
    output logic [NUM_CS-1:0]             cs_n
);

    localparam int unsigned CS_W  = $clog2(NUM_CS);
    localparam int unsigned EXT_W = SEG_W + 1;

    typedef struct packed {
        logic [EXT_W-1:0]  addr;
        logic [NUM_CS-1:0] sel_n;
    } out_t;

    map_mode_e         mode;
    logic [EXT_W-1:0]  map_ext;
    logic [CS_W-1:0]   map_idx;
    logic [NUM_CS-1:0] dec_sel_n;
    out_t              out_d;
    out_t              out_q;

    xbus_mode_detect #(.NUM_CS(NUM_CS)) u_mode (
        .big_dev (big_dev),
        .mode    (mode)
    );

    xbus_addr_map #(.NUM_CS(NUM_CS), .SEG_W(SEG_W)) u_map (
        .mode   (mode),
        .offset (win_offset),
        .ext    (map_ext),
        .idx    (map_idx)
    );

    xbus_cs_decode #(.NUM_CS(NUM_CS)) u_dec (
        .valid (acc_valid),
        .idx   (map_idx),
        .sel_n (dec_sel_n)
    );

    always_comb begin
        out_d       = out_q;
        out_d.sel_n = dec_sel_n;
        out_d.addr  = acc_valid ? map_ext : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.addr  <= '0;
            out_q.sel_n <= '1;
        end else begin
            out_q <= out_d;
        end
    end

    assign ext_addr = out_q.addr;
    assign cs_n     = out_q.sel_n;

endmodule

// File: rtl/xbus_cs_xlate_chk.sv
module xbus_cs_xlate_chk #(
    parameter int unsigned NUM_CS = 8,
    parameter int unsigned SEG_W  = 24
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          acc_valid,
    input logic [SEG_W+$clog2(NUM_CS):0] win_offset,
    input logic [NUM_CS-1:0]             big_dev,
    input logic [SEG_W:0]                ext_addr,
    input logic [NUM_CS-1:0]             cs_n
);

    localparam int unsigned CS_W = $clog2(NUM_CS);

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (&cs_n) && (ext_addr == '0)); // R1

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (&cs_n) && (ext_addr == '0)); // R3

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> ($countones(~cs_n) == 1)); // R10

    AST_NEVER_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R10

    AST_SMALL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && big_dev == '0) |=>
            (ext_addr == {1'b0, $past(win_offset[SEG_W-1:0])})); // R4

    AST_SMALL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && big_dev == '0) |=>
            !cs_n[$past(win_offset[SEG_W+CS_W-1:SEG_W])]); // R5

    AST_LARGE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && big_dev != '0) |=>
            (ext_addr == $past(win_offset[SEG_W:0]))); // R7

    AST_LARGE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && big_dev != '0) |=>
            !cs_n[$past(win_offset[SEG_W+CS_W:SEG_W+1])]); // R8

endmodule

bind xbus_cs_xlate xbus_cs_xlate_chk #(.NUM_CS(NUM_CS), .SEG_W(SEG_W)) u_chk (.*);

// File: tb/sim_xbus_cs_xlate.sv
module sim_xbus_cs_xlate;

    localparam int CLK_PERIOD = 10;
    localparam int NCS  = 8;
    localparam int SEGW = 24;
    localparam int OFSW = 28;
    localparam int EXTW = 25;
    localparam int WATCHDOG = 200000;

    typedef struct {
        logic [EXTW-1:0] addr;
        logic [NCS-1:0]  cs;
        int              due;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_valid = 1'b0;
    logic [OFSW-1:0] win_offset = '0;
    logic [NCS-1:0]  big_dev = '0;
    logic [EXTW-1:0] ext_addr;
    logic [NCS-1:0]  cs_n;

    int   checks = 0;
    int   failures = 0;
    int   cyc = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    xbus_cs_xlate u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .win_offset (win_offset),
        .big_dev    (big_dev),
        .ext_addr   (ext_addr),
        .cs_n       (cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [EXTW-1:0] ea,
                         input logic [NCS-1:0] ec);
        checks++;
        if (ext_addr !== ea || cs_n !== ec) begin
            failures++;
            $display("FAIL %s: got addr=%h cs_n=%b expected addr=%h cs_n=%b",
                     tag, ext_addr, cs_n, ea, ec);
        end
    endtask

    // Model written from the requirements.
    task automatic drive(input logic v, input logic [OFSW-1:0] ofs,
                         input logic [NCS-1:0] big, input string tag);
        exp_t e;
        int   idx;
        @(negedge clk);
        acc_valid  = v;
        win_offset = ofs;
        big_dev    = big;
        if (!v) begin
            e.addr = '0;                         // R3
            e.cs   = '1;
        end else if (big == '0) begin
            e.addr = {1'b0, ofs[23:0]};          // R4
            idx    = int'(ofs[26:24]);           // R5, R6
            e.cs   = ~(NCS'(1) << idx);
        end else begin
            e.addr = ofs[24:0];                  // R7
            idx    = int'(ofs[27:25]);           // R8
            e.cs   = ~(NCS'(1) << idx);
        end
        e.due = cyc + 1;                         // R2
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares one cycle after each push.
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, e.addr, e.cs);
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", '0, '1);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 after release", '0, '1);

        // Region edges in the 16 MB layout, with their bit-27 aliases.
        for (int i = 0; i < NCS; i++) begin
            drive(1'b1, OFSW'(i) << 24, '0, "R5 small region start");
            drive(1'b1, (OFSW'(i) << 24) | 28'h0FF_FFFF, '0, "R4 small region end");
            drive(1'b1, (OFSW'(i) << 24) | 28'h800_0000, '0, "R6 alias start");
            drive(1'b1, (OFSW'(i) << 24) | 28'h8FF_FFFF, '0, "R6 alias end");
        end
        // Region edges in the 32 MB layout.
        for (int i = 0; i < NCS; i++) begin
            drive(1'b1, OFSW'(i) << 25, 8'h01, "R8 large region start");
            drive(1'b1, (OFSW'(i) << 25) | 28'h1FF_FFFF, 8'h80, "R7 large region end");
        end
        // Each flag on its own enables the large map.
        for (int b = 0; b < NCS; b++) begin
            drive(1'b1, 28'h1ABC_DEF, NCS'(1) << b, "R7 single flag");
        end
        // Idle cycles with non-zero inputs.
        drive(1'b0, 28'hFFF_FFFF, 8'hFF, "R3 idle large");
        drive(1'b0, 28'h3FF_FFFF, 8'h00, "R3 idle small");
        // Mode flips between back-to-back accesses.
        drive(1'b1, 28'h100_0000, 8'h00, "R9 small then");
        drive(1'b1, 28'h100_0000, 8'h04, "R9 large now");
        drive(1'b1, 28'h100_0000, 8'h00, "R9 small again");
        drive(1'b1, 28'hE00_0000, 8'h10, "R9 large top");
        // Mixed pseudo-random run.
        lfsr = 16'hACE1;
        for (int n = 0; n < 300; n++) begin
            logic [OFSW-1:0] o;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            o = {lfsr[11:0], lfsr} ^ (OFSW'(n) << 20);
            drive(lfsr[0] | lfsr[3], o,
                  lfsr[5] ? NCS'(lfsr[9:7]) << lfsr[2:1] : '0, "R10 mixed");
        end
        drive(1'b0, '0, '0, "R3 final idle");
        @(negedge clk);
        @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL R2: got %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule